// File: doc/BRIEF.md
# PCM Time-Space Slot Interchange Switch

This block is a non-blocking switch for serial PCM traffic. It terminates eight serial input lines and drives eight serial output lines. Each line carries a frame of 32 eight-bit channels. Every input byte is assembled from its line, MSB first, and stored in a speech memory at a fixed word. The word is given by the line and the slot in which the byte arrived. The speech memory has two banks that swap at each frame boundary. One bank fills with the frame in progress while the other is read out.

Each output line and slot has its own entry in a connection memory. That entry names the stored input byte to send, as an input line and an input slot. One stage therefore performs both time and space switching. Each output byte appears exactly one frame after the input frame that carried it.

A small 8-bit host bus with chip select, read, write and one address bit reaches the connection memory through an indirect address register. A frame sync pulse aligns the bit, slot and frame counters on all lines. A mode pin selects 2 or 4 clocks per serial bit.

Top module: `tsi_switch`

## Requirements
- R1: After reset every serial output is 0, the address register reads 0, and every connection-memory entry holds its own address (straight-through map).
- R2: With `clk_x4` = 0 a serial bit lasts 2 clocks, and with `clk_x4` = 1 it lasts 4 clocks. Each input bit is sampled only in the last clock of its bit period. Each output bit stays constant for the whole bit period.
- R3: When `fsync` is high at a clock edge, the next clock is the first clock of bit 0 of slot 0 on every line, wherever the counters stood. Without `fsync` the frame of 32 slots repeats with no gap.
- R4: A slot is 8 consecutive bits sent MSB first, and slots follow in order 0 to 31. The byte received on input line L in slot S is stored at speech word L*32+S, with the line in bits 7:5 and the slot in bits 4:0.
- R5: Output line L in slot S of frame F+1 carries the byte that arrived in frame F at the line and slot named by connection entry L*32+S (bits 7:5 line, bits 4:0 slot). This holds for any selection, including input slot 31, and for one input sent to several outputs.
- R6: A write with `cs_n`=0, `wr_n`=0 and `a0`=1 loads `host_din` into the address register at the clock edge. A read with `cs_n`=0, `rd_n`=0 and `a0`=1 returns the address register on `host_dout`.
- R7: A write with `a0`=0 stores `host_din` into the connection entry named by the address register and leaves every other entry unchanged. A read with `a0`=0 returns that entry in the same cycle.
- R8: `host_dout` is 0 unless `cs_n` and `rd_n` are both low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_x4 | input | 1 | 0: 2 clocks per bit, 1: 4 clocks per bit |
| fsync | input | 1 | Frame alignment pulse, one clock wide |
| ser_in | input | 8 | Serial PCM inputs, one bit per line |
| ser_out | output | 8 | Serial PCM outputs, one bit per line |
| cs_n | input | 1 | Host chip select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| a0 | input | 1 | 1: address register, 0: connection entry |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Host read data |

## Verification
Each class of internal fault shows up on the output lines after a predictable delay:

- **Bit, slot or phase counter:** a slip pushes bits into the wrong slot, so the next byte compared on a line is wrong. This appears within one slot.
- **Bank select or last-slot path:** these show up one frame late, and only in outputs that select the affected bytes. The bench therefore runs several frames and maps some outputs to input slot 31.
- **Connection entry:** a corrupted entry sends the wrong byte in exactly one output slot per frame. It can also be read back over the host bus at once.

Driving each input bit inverted outside its sampling clock turns a sampling-point error into wrong data within one byte.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

   // Serial bit-rate selection: clocks per serial bit.
   typedef enum logic {
      RATE_X2 = 1'b0,
      RATE_X4 = 1'b1
   } rate_e;

   // Timing strobes shared by the lanes and memories.
   typedef struct packed {
      logic bit_end;    // last clock of a bit period
      logic slot_end;   // last clock of the last bit of a slot
      logic frame_end;  // last clock of slot SLOTS-1 (natural wrap)
      logic tick;       // bank swap event: sync pulse or natural wrap
   } strobe_t;

endpackage

// File: rtl/tsi_timing.sv
module tsi_timing
   import tsi_pkg::*;
#(
   parameter int SLOTS  = 32,
   parameter int BITS   = 8,
   parameter int DIV_LO = 2,
   parameter int DIV_HI = 4,
   localparam int SW = $clog2(SLOTS),
   localparam int BW = $clog2(BITS),
   localparam int PW = $clog2(DIV_HI)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  rate_e         rate,
   input  logic          fsync,
   output strobe_t       strb,
   output logic [PW-1:0] ph_o,
   output logic [BW-1:0] bit_o,
   output logic [SW-1:0] slot_o,
   output logic [SW-1:0] nslot_o,
   output logic          bank_o
);

   logic [PW-1:0] ph_q;
   logic [BW-1:0] bit_q;
   logic [SW-1:0] slot_q;
   logic          bank_q;
   logic [PW-1:0] ph_last;
   logic          last_bit;
   logic          last_slot;

   assign ph_last   = (rate == RATE_X4) ? PW'(DIV_HI - 1) : PW'(DIV_LO - 1);
   assign last_bit  = (bit_q == BW'(BITS - 1));
   assign last_slot = (slot_q == SW'(SLOTS - 1));

   always_comb begin
      strb.bit_end   = (ph_q == ph_last);
      strb.slot_end  = strb.bit_end && last_bit;
      strb.frame_end = strb.slot_end && last_slot;
      strb.tick      = fsync || strb.frame_end;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= '0;
         bit_q  <= '0;
         slot_q <= '0;
      end else if (fsync) begin
         ph_q   <= '0;
         bit_q  <= '0;
         slot_q <= '0;
      end else if (strb.bit_end) begin
         ph_q <= '0;
         if (last_bit) begin
            bit_q  <= '0;
            slot_q <= last_slot ? '0 : slot_q + 1'b1;
         end else begin
            bit_q <= bit_q + 1'b1;
         end
      end else begin
         ph_q <= ph_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bank_q <= 1'b0;
      else if (strb.tick) bank_q <= ~bank_q;
   end

   assign ph_o    = ph_q;
   assign bit_o   = bit_q;
   assign slot_o  = slot_q;
   assign bank_o  = bank_q;
   assign nslot_o = (fsync || last_slot) ? '0 : slot_q + 1'b1;

endmodule

// File: rtl/tsi_rx_lane.sv
module tsi_rx_lane #(
   parameter int BITS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sin,
   input  logic            sample,
   output logic [BITS-1:0] byte_o
);

   logic [BITS-2:0] sr_q;

   // The byte completes in the clock that samples its last bit.
   assign byte_o = {sr_q, sin};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sr_q <= '0;
      else if (sample) sr_q <= byte_o[BITS-2:0];
   end

endmodule

// File: rtl/tsi_tx_lane.sv
module tsi_tx_lane #(
   parameter int BITS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            shift,
   input  logic [BITS-1:0] ld_byte,
   output logic            sout
);

   logic [BITS-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sr_q <= '0;
      else if (load)  sr_q <= ld_byte;
      else if (shift) sr_q <= {sr_q[BITS-2:0], 1'b0};
   end

   assign sout = sr_q[BITS-1];

endmodule

// File: rtl/tsi_speech_mem.sv
module tsi_speech_mem #(
   parameter int LINES = 8,
   parameter int SLOTS = 32,
   parameter int BITS  = 8,
   localparam int LW    = $clog2(LINES),
   localparam int SW    = $clog2(SLOTS),
   localparam int AW    = LW + SW,
   localparam int DEPTH = LINES * SLOTS
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic                       wbank,
   input  logic [SW-1:0]              wslot,
   input  logic [LINES-1:0][BITS-1:0] wdata,
   input  logic                       rbank,
   input  logic [LINES-1:0][AW-1:0]   raddr,
   output logic [LINES-1:0][BITS-1:0] rdata
);

   logic [BITS-1:0] mem_q [2][DEPTH];

   // All lines finish a slot together, so one write event stores one byte per line.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < 2; b++)
            for (int i = 0; i < DEPTH; i++)
               mem_q[b][i] <= '0;
      end else if (we) begin
         for (int l = 0; l < LINES; l++)
            mem_q[wbank][{LW'(l), wslot}] <= wdata[l];
      end
   end

   always_comb begin
      for (int l = 0; l < LINES; l++)
         rdata[l] = mem_q[rbank][raddr[l]];
   end

endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
   parameter int LINES  = 8,
   parameter int SLOTS  = 32,
   parameter int HOST_W = 8,
   localparam int LW    = $clog2(LINES),
   localparam int SW    = $clog2(SLOTS),
   localparam int AW    = LW + SW,
   localparam int DEPTH = LINES * SLOTS
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cs_n,
   input  logic                     rd_n,
   input  logic                     wr_n,
   input  logic                     a0,
   input  logic [HOST_W-1:0]        din,
   output logic [HOST_W-1:0]        dout,
   input  logic [SW-1:0]            rslot,
   output logic [LINES-1:0][AW-1:0] sel,
   output logic [AW-1:0]            addr_o
);

   logic [AW-1:0] cm_q [DEPTH];
   logic [AW-1:0] addr_q;
   logic          wr_stb;
   logic          rd_stb;

   assign wr_stb = !cs_n && !wr_n;
   assign rd_stb = !cs_n && !rd_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         for (int i = 0; i < DEPTH; i++)
            cm_q[i] <= AW'(i);
      end else if (wr_stb) begin
         if (a0) addr_q         <= din[AW-1:0];
         else    cm_q[addr_q]   <= din[AW-1:0];
      end
   end

   assign dout   = rd_stb ? HOST_W'(a0 ? addr_q : cm_q[addr_q]) : '0;
   assign addr_o = addr_q;

   // One lookup per output line for the slot about to be loaded.
   always_comb begin
      for (int l = 0; l < LINES; l++)
         sel[l] = cm_q[{LW'(l), rslot}];
   end

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
   import tsi_pkg::*;
#(
   parameter int LINES  = 8,
   parameter int SLOTS  = 32,
   parameter int BITS   = 8,
   parameter int DIV_LO = 2,
   parameter int DIV_HI = 4,
   parameter int HOST_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_x4,
   input  logic              fsync,
   input  logic [LINES-1:0]  ser_in,
   output logic [LINES-1:0]  ser_out,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              a0,
   input  logic [HOST_W-1:0] host_din,
   output logic [HOST_W-1:0] host_dout
);

   localparam int LW = $clog2(LINES);
   localparam int SW = $clog2(SLOTS);
   localparam int AW = LW + SW;
   localparam int BW = $clog2(BITS);
   localparam int PW = $clog2(DIV_HI);

   // Elaboration-time parameter checks.
   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("tsi_switch: LINES must be a power of two, at least 2");
   end
   if (SLOTS < 2 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
      $error("tsi_switch: SLOTS must be a power of two, at least 2");
   end
   if (BITS < 2) begin : g_bad_bits
      $error("tsi_switch: BITS must be at least 2");
   end
   if (DIV_LO < 1 || DIV_HI <= DIV_LO) begin : g_bad_div
      $error("tsi_switch: need 1 <= DIV_LO < DIV_HI");
   end
   if (AW > HOST_W) begin : g_bad_host
      $error("tsi_switch: host bus narrower than a connection entry");
   end

   strobe_t                    strb;
   logic [PW-1:0]              ph_w;
   logic [BW-1:0]              bit_w;
   logic [SW-1:0]              slot_w;
   logic [SW-1:0]              nslot_w;
   logic                       wr_bank;
   logic                       rd_bank;
   logic [AW-1:0]              addr_w;
   logic [LINES-1:0][BITS-1:0] rx_bytes;
   logic [LINES-1:0][BITS-1:0] sm_rdata;
   logic [LINES-1:0][AW-1:0]   sel;
   logic                       tx_load;

   tsi_timing #(
      .SLOTS (SLOTS),
      .BITS  (BITS),
      .DIV_LO(DIV_LO),
      .DIV_HI(DIV_HI)
   ) u_tim (
      .clk    (clk),
      .rst_n  (rst_n),
      .rate   (rate_e'(clk_x4)),
      .fsync  (fsync),
      .strb   (strb),
      .ph_o   (ph_w),
      .bit_o  (bit_w),
      .slot_o (slot_w),
      .nslot_o(nslot_w),
      .bank_o (wr_bank)
   );

   // At a frame event the bank just filled becomes the read bank for the new frame.
   assign rd_bank = strb.tick ? wr_bank : ~wr_bank;
   assign tx_load = strb.slot_end || fsync;

   tsi_conn_mem #(
      .LINES (LINES),
      .SLOTS (SLOTS),
      .HOST_W(HOST_W)
   ) u_cm (
      .clk   (clk),
      .rst_n (rst_n),
      .cs_n  (cs_n),
      .rd_n  (rd_n),
      .wr_n  (wr_n),
      .a0    (a0),
      .din   (host_din),
      .dout  (host_dout),
      .rslot (nslot_w),
      .sel   (sel),
      .addr_o(addr_w)
   );

   tsi_speech_mem #(
      .LINES(LINES),
      .SLOTS(SLOTS),
      .BITS (BITS)
   ) u_sm (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (strb.slot_end),
      .wbank(wr_bank),
      .wslot(slot_w),
      .wdata(rx_bytes),
      .rbank(rd_bank),
      .raddr(sel),
      .rdata(sm_rdata)
   );

   for (genvar l = 0; l < LINES; l++) begin : g_lane
      logic [LW-1:0]   src_line;
      logic [SW-1:0]   src_slot;
      logic            bypass;
      logic [BITS-1:0] out_byte;

      assign src_line = sel[l][AW-1:SW];
      assign src_slot = sel[l][SW-1:0];
      // The last slot's byte is written at the same edge that loads slot 0.
      assign bypass   = strb.frame_end && (src_slot == SW'(SLOTS - 1));
      assign out_byte = bypass ? rx_bytes[src_line] : sm_rdata[l];

      tsi_rx_lane #(.BITS(BITS)) u_rx (
         .clk   (clk),
         .rst_n (rst_n),
         .sin   (ser_in[l]),
         .sample(strb.bit_end),
         .byte_o(rx_bytes[l])
      );

      tsi_tx_lane #(.BITS(BITS)) u_tx (
         .clk    (clk),
         .rst_n  (rst_n),
         .load   (tx_load),
         .shift  (strb.bit_end),
         .ld_byte(out_byte),
         .sout   (ser_out[l])
      );
   end

endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
   parameter int LINES  = 8,
   parameter int SLOTS  = 32,
   parameter int BITS   = 8,
   parameter int DIV_LO = 2,
   parameter int DIV_HI = 4,
   parameter int HOST_W = 8,
   localparam int LW = $clog2(LINES),
   localparam int SW = $clog2(SLOTS),
   localparam int AW = LW + SW,
   localparam int BW = $clog2(BITS),
   localparam int PW = $clog2(DIV_HI)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clk_x4,
   input logic              fsync,
   input logic [LINES-1:0]  ser_out,
   input logic [PW-1:0]     ph,
   input logic [BW-1:0]     bc,
   input logic [SW-1:0]     sc,
   input logic              wr_bank,
   input logic              tick,
   input logic              bit_end,
   input logic              cs_n,
   input logic              wr_n,
   input logic              a0,
   input logic [HOST_W-1:0] host_din,
   input logic [AW-1:0]     addr_q
);

   assert_phase_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ph <= (clk_x4 ? PW'(DIV_HI - 1) : PW'(DIV_LO - 1)));

   assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(bit_end || fsync) |=> $stable(ser_out));

   assert_sync_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fsync |=> (ph == '0 && bc == '0 && sc == '0));

   assert_bank_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (wr_bank != $past(wr_bank)));

   assert_bank_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(wr_bank));

   assert_addr_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !wr_n && a0) |=> (addr_q == $past(host_din[AW-1:0])));

endmodule

bind tsi_switch tsi_switch_chk #(
   .LINES (LINES),
   .SLOTS (SLOTS),
   .BITS  (BITS),
   .DIV_LO(DIV_LO),
   .DIV_HI(DIV_HI),
   .HOST_W(HOST_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .clk_x4  (clk_x4),
   .fsync   (fsync),
   .ser_out (ser_out),
   .ph      (ph_w),
   .bc      (bit_w),
   .sc      (slot_w),
   .wr_bank (wr_bank),
   .tick    (strb.tick),
   .bit_end (strb.bit_end),
   .cs_n    (cs_n),
   .wr_n    (wr_n),
   .a0      (a0),
   .host_din(host_din),
   .addr_q  (addr_w)
);

// File: tb/tsi_switch_bench.sv
module tsi_switch_bench;

   localparam int CLK_PERIOD = 10;
   localparam int LINES      = 8;
   localparam int SLOTS      = 32;
   localparam int CH         = LINES * SLOTS;
   localparam int WATCHDOG   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clk_x4 = 1'b0;
   logic       fsync = 1'b0;
   logic [7:0] ser_in = '0;
   logic [7:0] ser_out;
   logic       cs_n = 1'b1;
   logic       rd_n = 1'b1;
   logic       wr_n = 1'b1;
   logic       a0 = 1'b0;
   logic [7:0] host_din = '0;
   logic [7:0] host_dout;

   int n_cmp = 0;
   int n_bad = 0;

   logic [7:0] cm_m   [CH];
   logic [7:0] cur_b  [CH];
   logic [7:0] prev_b [CH];

   always #(CLK_PERIOD/2) clk = ~clk;

   tsi_switch u_tsi_switch (
      .clk      (clk),
      .rst_n    (rst_n),
      .clk_x4   (clk_x4),
      .fsync    (fsync),
      .ser_in   (ser_in),
      .ser_out  (ser_out),
      .cs_n     (cs_n),
      .rd_n     (rd_n),
      .wr_n     (wr_n),
      .a0       (a0),
      .host_din (host_din),
      .host_dout(host_dout)
   );

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic rate);
      @(negedge clk);
      rst_n = 1'b0; clk_x4 = rate; fsync = 1'b0; ser_in = '0;
      cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; a0 = 1'b0; host_din = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < CH; i++) cm_m[i] = 8'(i);
      @(negedge clk);
   endtask

   task automatic host_write(input logic sel, input logic [7:0] d);
      cs_n = 1'b0; wr_n = 1'b0; a0 = sel; host_din = d;
      @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1;
   endtask

   task automatic host_read(input logic sel, output logic [7:0] d);
      cs_n = 1'b0; rd_n = 1'b0; a0 = sel;
      #1 d = host_dout;
      cs_n = 1'b1; rd_n = 1'b1;
   endtask

   task automatic cm_program(input logic [7:0] addr, input logic [7:0] val);
      host_write(1'b1, addr);
      host_write(1'b0, val);
      cm_m[addr] = val;
   endtask

   // Starts each call with a sync pulse, then streams nfr frames.
   // Frame 0 output is not compared; later frames are compared against the model.
   task automatic run_frames(input int nfr, input bit sync_each, input string tag);
      int         div;
      int         fl;
      logic [7:0] cap  [LINES];
      logic       hold [LINES];
      logic       bref [LINES];
      div = clk_x4 ? 4 : 2;
      fl  = CH * div / LINES * 8 / 8;
      fl  = SLOTS * 8 * div;
      for (int l = 0; l < LINES; l++) begin cap[l] = '0; hold[l] = 1'b0; bref[l] = 1'b0; end
      fsync = 1'b1;
      @(negedge clk);
      fsync = 1'b0;
      for (int f = 0; f < nfr; f++) begin
         for (int i = 0; i < CH; i++) cur_b[i] = 8'($urandom);
         for (int k = 0; k < fl; k++) begin
            int ph;
            int bt;
            int sl;
            ph = k % div;
            bt = (k / div) % 8;
            sl = k / (div * 8);
            for (int l = 0; l < LINES; l++) begin
               if (ph == 0) begin
                  bref[l] = ser_out[l];
                  cap[l]  = {cap[l][6:0], ser_out[l]};
               end else if (ser_out[l] !== bref[l]) begin
                  hold[l] = 1'b1;
               end
               if (bt == 7 && ph == div - 1) begin
                  if (f >= 1) begin
                     logic [7:0] sel;
                     sel = cm_m[l * SLOTS + sl];
                     check($sformatf("R5 %s line %0d slot %0d frame %0d (R2 hold flag in bit 8)",
                                     tag, l, sl, f),
                           {23'd0, hold[l], cap[l]}, {24'd0, prev_b[sel]});
                  end
                  hold[l] = 1'b0;
               end
            end
            for (int l = 0; l < LINES; l++) begin
               logic b;
               b = cur_b[l * SLOTS + sl][7 - bt];
               // R2: the wrong value outside the sampling clock must not be captured.
               ser_in[l] = (ph == div - 1) ? b : ~b;
            end
            fsync = (sync_each && k == fl - 1) ? 1'b1 : 1'b0;
            @(negedge clk);
         end
         for (int i = 0; i < CH; i++) prev_b[i] = cur_b[i];
      end
      fsync = 1'b0;
   endtask

   task automatic test_reset();
      logic [7:0] d;
      do_reset(1'b0);
      check("R1 serial outputs after reset", ser_out, 0);
      check("R8 idle bus output", host_dout, 0);
      host_read(1'b1, d);
      check("R1 address register after reset", d, 0);
      host_read(1'b0, d);
      check("R1 identity entry 0", d, 8'h00);
      host_write(1'b1, 8'hff);
      host_read(1'b0, d);
      check("R1 identity entry 255", d, 8'hff);
      host_write(1'b1, 8'h47);
      host_read(1'b0, d);
      check("R1 identity entry 0x47", d, 8'h47);
   endtask

   task automatic test_host();
      logic [7:0] d;
      host_write(1'b1, 8'h5a);
      host_read(1'b1, d);
      check("R6 address register readback", d, 8'h5a);
      host_write(1'b0, 8'h13);
      cm_m[8'h5a] = 8'h13;
      host_read(1'b0, d);
      check("R7 entry write readback", d, 8'h13);
      host_write(1'b1, 8'h5b);
      host_read(1'b0, d);
      check("R7 neighbour entry untouched", d, 8'h5b);
      host_write(1'b1, 8'h59);
      host_read(1'b0, d);
      check("R7 lower neighbour untouched", d, 8'h59);
      cs_n = 1'b1; rd_n = 1'b0; a0 = 1'b1;
      #1 check("R8 read strobe without select", host_dout, 0);
      cs_n = 1'b0; rd_n = 1'b1;
      #1 check("R8 select without read strobe", host_dout, 0);
      cs_n = 1'b1;
      cm_program(8'h5a, 8'h5a);
   endtask

   task automatic test_passthrough();
      do_reset(1'b0);
      run_frames(3, 1'b0, "R1 R4 identity x2");
   endtask

   task automatic program_map();
      for (int i = 0; i < 40; i++)
         cm_program(8'($urandom_range(255)), 8'($urandom_range(255)));
      cm_program(8'h00, 8'hff);   // line 0 slot 0 <- line 7 slot 31
      cm_program(8'hff, 8'hff);   // line 7 slot 31 <- line 7 slot 31 (shared source)
      cm_program(8'h3f, 8'h1f);   // line 1 slot 31 <- line 0 slot 31
      cm_program(8'h65, 8'h00);   // line 3 slot 5  <- line 0 slot 0
      cm_program(8'h21, 8'h00);   // line 1 slot 1  <- line 0 slot 0
   endtask

   task automatic test_random_map();
      do_reset(1'b1);
      program_map();
      run_frames(3, 1'b0, "R2 R5 random map x4");
   endtask

   task automatic test_resync();
      do_reset(1'b0);
      program_map();
      repeat (137) @(negedge clk);
      run_frames(3, 1'b1, "R3 mid-frame sync then per-frame sync");
   endtask

   task automatic run_all();
      test_reset();
      test_host();
      test_passthrough();
      test_random_map();
      test_resync();
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (WATCHDOG) @(posedge clk);
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all requirements): actual expired expected completion");
         end
      join_any
      disable fork;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule